// File: doc/BRIEF.md
# Vector Operand Overlap Legality Checker

This block sits beside the decode stage of a vector unit. It receives decoded register numbers and the operand shapes for one instruction. The element width and group multiplier of each operand are already resolved from the current dynamic type state. The block reports whether the instruction must be refused as illegal. The decision does not come from the opcode alone. It depends on which register groups intersect and on the widths at which those groups are read. The same encoding can therefore be legal under one type setting and illegal under another.

Each operand is described by a base register, an element-width code and a signed log2 group multiplier. The block expands each operand into a register range and compares every pair of ranges that are read. It applies four rules and reports the most urgent one as a cause code, along with a single illegal flag. Both outputs are registered by default, so they appear one clock after the inputs. A parameter selects a purely combinational output instead.

Top module: `vreg_overlap_check`

## Requirements
- R1: The cause codes are 0 legal, 1 mixed-width source overlap, 2 mask overlap, 3 widened group too large, 4 misaligned group. `illegal_o` is 1 exactly when `cause_o` is nonzero. Both outputs are 0 during reset. With the default registered output, both outputs reflect the inputs sampled at the previous rising clock edge.
- R2: A group covers registers base through base+max(1,2^emul)-1, where emul is the 4-bit two's complement log2 multiplier. Width codes 0..3 mean 8, 16, 32 and 64 bits. If two vector sources that are read have intersecting ranges and different width codes, the cause is 1.
- R3: Class code 3 is an indexed store. Its read sources are the index group on `vs2_*` and the store-data group on `vd_*`; the `vs1_*` fields are ignored. If the index and data groups overlap with different widths, the cause is 1.
- R4: Class code 1 is a widening operation with a wide source. Its sources are the wide group on `vs2_*` and the narrow group on `vs1_*`. If these overlap with different widths, the cause is 1.
- R5: When `mask_en_i` is 1, any read source group that contains register 0 gives cause 2. When `mask_en_i` is 0, this rule never fires. A destination that is written only (classes 0 and 1) is not a source for this rule.
- R6: For widening classes 1 and 2, a wide group (`vd_*`, and for class 1 also `vs2_*`) with emul above 3 spans more than 8 registers and gives cause 3. Classes 0 and 3 never give cause 3.
- R7: Any vector operand in use whose base is not a multiple of its group count gives cause 4. Classes 0 to 2 use all three operands; class 3 does not use `vs1_*`.
- R8: When several rules apply, the lowest nonzero cause code is reported.
- R9: Sources that overlap, or that name the same register, with identical width codes are legal under the overlap rule.
- R10: Class code 2 is widening multiply-accumulate, and it reads `vd_*` as a source. Take the case where destination, both sources and the mask are all register 0, the sources use width code 2 and the destination uses width code 3. This case reports cause 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cls_i | input | 2 | Instruction class: 0 plain, 1 widening with wide source, 2 widening multiply-accumulate, 3 indexed store |
| mask_en_i | input | 1 | Masking enabled, so register 0 is read as mask bits |
| vs1_i | input | 5 | First source base register |
| vs1_eew_i | input | 2 | First source width code |
| vs1_emul_i | input | 4 | First source log2 group multiplier, two's complement |
| vs2_i | input | 5 | Second source base register (index group for stores) |
| vs2_eew_i | input | 2 | Second source width code |
| vs2_emul_i | input | 4 | Second source log2 group multiplier |
| vd_i | input | 5 | Destination base register (store data for class 3) |
| vd_eew_i | input | 2 | Destination width code |
| vd_emul_i | input | 4 | Destination log2 group multiplier |
| illegal_o | output | 1 | Instruction must be refused |
| cause_o | output | 3 | Rule that fired, lowest code first |

## Verification
The bench aims at range edges: groups that touch without sharing a register, partial intersections of a small group inside a large one, and a group that starts at register 0 and covers the mask register. A design that computed the range end one register short, or tested only the base numbers, would miss partial overlaps or flag adjacent groups. Class-dependent operand roles are also probed. A design that treated an indexed store's unused first source as a vector would report spurious overlaps and misalignments. A design that treated a multiply-accumulate destination as write-only would miss the all-register-0 worst case. Combined violations check priority, where a wrong ordering reports mask or misalignment in place of the more urgent cause.

// File: rtl/vreg_overlap_pkg.sv
package vreg_overlap_pkg;

    typedef enum logic [1:0] {
        CLS_PLAIN     = 2'd0,
        CLS_WIDE_SRC  = 2'd1,
        CLS_WIDE_MAC  = 2'd2,
        CLS_IDX_STORE = 2'd3
    } op_class_e;

    typedef enum logic [2:0] {
        RSN_NONE  = 3'd0,
        RSN_MIXED = 3'd1,
        RSN_MASK  = 3'd2,
        RSN_WIDE  = 3'd3,
        RSN_ALIGN = 3'd4
    } reason_e;

    localparam int NUM_OPS = 3;
    localparam int OP_VS1  = 0;
    localparam int OP_VS2  = 1;
    localparam int OP_VD   = 2;

endpackage

// File: rtl/vreg_group_span.sv
module vreg_group_span #(
    parameter int RW = 5,
    parameter int EW = 4,
    parameter int SW = 8
) (
    input  logic [RW-1:0] base_i,
    input  logic [EW-1:0] emul_i,
    output logic [SW-1:0] lo_o,
    output logic [SW-1:0] hi_o,
    output logic          misal_o
);

    logic [SW-1:0] cnt;

    always_comb begin
        // negative or zero log2 multiplier still occupies one register
        if (!emul_i[EW-1] && (emul_i != '0)) begin
            cnt = SW'(1) << emul_i[EW-2:0];
        end else begin
            cnt = SW'(1);
        end
        lo_o    = SW'(base_i);
        hi_o    = lo_o + cnt - SW'(1);
        misal_o = |(lo_o & (cnt - SW'(1)));
    end

endmodule

// File: rtl/vreg_rule_eval.sv
module vreg_rule_eval
    import vreg_overlap_pkg::*;
#(
    parameter int EW      = 4,
    parameter int SW      = 8,
    parameter int EEW_W   = 2,
    parameter int LIM_LOG = 3
) (
    input  op_class_e                        cls_i,
    input  logic                             mask_en_i,
    input  logic [NUM_OPS-1:0][SW-1:0]       lo_i,
    input  logic [NUM_OPS-1:0][SW-1:0]       hi_i,
    input  logic [NUM_OPS-1:0]               misal_i,
    input  logic [NUM_OPS-1:0][EEW_W-1:0]    eew_i,
    input  logic [NUM_OPS-1:0][EW-1:0]       emul_i,
    output reason_e                          cause_o,
    output logic                             hit_o
);

    logic [NUM_OPS-1:0] rd;
    logic [NUM_OPS-1:0] used;
    logic [NUM_OPS-1:0] at_v0;
    logic               mixed_hit;
    logic               mask_hit;
    logic               wide_hit;
    logic               align_hit;
    logic               is_wide;

    function automatic logic too_wide(input logic [EW-1:0] m);
        return !m[EW-1] && (m[EW-2:0] > (EW-1)'(LIM_LOG));
    endfunction

    // operand roles per class
    always_comb begin
        unique case (cls_i)
            CLS_PLAIN:     begin rd = 3'b011; used = 3'b111; end
            CLS_WIDE_SRC:  begin rd = 3'b011; used = 3'b111; end
            CLS_WIDE_MAC:  begin rd = 3'b111; used = 3'b111; end
            CLS_IDX_STORE: begin rd = 3'b110; used = 3'b110; end
        endcase
    end

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_v0
        assign at_v0[k] = (lo_i[k] == '0);
    end

    always_comb begin
        mixed_hit = 1'b0;
        for (int i = 0; i < NUM_OPS; i++) begin
            for (int j = i + 1; j < NUM_OPS; j++) begin
                if (rd[i] && rd[j] && (lo_i[i] <= hi_i[j]) && (lo_i[j] <= hi_i[i])
                    && (eew_i[i] != eew_i[j])) begin
                    mixed_hit = 1'b1;
                end
            end
        end
    end

    assign mask_hit  = mask_en_i && |(rd & at_v0);
    assign is_wide   = (cls_i == CLS_WIDE_SRC) || (cls_i == CLS_WIDE_MAC);
    assign wide_hit  = is_wide && (too_wide(emul_i[OP_VD]) ||
                       ((cls_i == CLS_WIDE_SRC) && too_wide(emul_i[OP_VS2])));
    assign align_hit = |(used & misal_i);

    always_comb begin
        if (mixed_hit)      cause_o = RSN_MIXED;
        else if (mask_hit)  cause_o = RSN_MASK;
        else if (wide_hit)  cause_o = RSN_WIDE;
        else if (align_hit) cause_o = RSN_ALIGN;
        else                cause_o = RSN_NONE;
    end

    assign hit_o = mixed_hit | mask_hit | wide_hit | align_hit;

endmodule

// File: rtl/vreg_overlap_check.sv
module vreg_overlap_check
    import vreg_overlap_pkg::*;
#(
    parameter int NUM_VREGS = 32,
    parameter int EEW_W     = 2,
    parameter int EMUL_W    = 4,
    parameter int MAX_GROUP = 8,
    parameter int REG_OUT   = 1,
    localparam int RW       = $clog2(NUM_VREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cls_i,
    input  logic              mask_en_i,
    input  logic [RW-1:0]     vs1_i,
    input  logic [EEW_W-1:0]  vs1_eew_i,
    input  logic [EMUL_W-1:0] vs1_emul_i,
    input  logic [RW-1:0]     vs2_i,
    input  logic [EEW_W-1:0]  vs2_eew_i,
    input  logic [EMUL_W-1:0] vs2_emul_i,
    input  logic [RW-1:0]     vd_i,
    input  logic [EEW_W-1:0]  vd_eew_i,
    input  logic [EMUL_W-1:0] vd_emul_i,
    output logic              illegal_o,
    output logic [2:0]        cause_o
);

    localparam int MAXLOG  = 2 ** (EMUL_W - 1) - 1;
    localparam int SW      = ((RW > MAXLOG) ? RW : MAXLOG) + 1;
    localparam int LIM_LOG = $clog2(MAX_GROUP);

    logic [NUM_OPS-1:0][RW-1:0]     base;
    logic [NUM_OPS-1:0][EEW_W-1:0]  eew;
    logic [NUM_OPS-1:0][EMUL_W-1:0] emul;
    logic [NUM_OPS-1:0][SW-1:0]     lo;
    logic [NUM_OPS-1:0][SW-1:0]     hi;
    logic [NUM_OPS-1:0]             misal;
    reason_e                        cause_d;
    logic                           hit_d;

    assign base = {vd_i, vs2_i, vs1_i};
    assign eew  = {vd_eew_i, vs2_eew_i, vs1_eew_i};
    assign emul = {vd_emul_i, vs2_emul_i, vs1_emul_i};

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_span
        vreg_group_span #(.RW(RW), .EW(EMUL_W), .SW(SW)) u_span (
            .base_i  (base[k]),
            .emul_i  (emul[k]),
            .lo_o    (lo[k]),
            .hi_o    (hi[k]),
            .misal_o (misal[k])
        );
    end

    vreg_rule_eval #(.EW(EMUL_W), .SW(SW), .EEW_W(EEW_W), .LIM_LOG(LIM_LOG)) u_rules (
        .cls_i     (op_class_e'(cls_i)),
        .mask_en_i (mask_en_i),
        .lo_i      (lo),
        .hi_i      (hi),
        .misal_i   (misal),
        .eew_i     (eew),
        .emul_i    (emul),
        .cause_o   (cause_d),
        .hit_o     (hit_d)
    );

    if (REG_OUT != 0) begin : g_reg
        reason_e cause_q;
        logic    flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cause_q <= RSN_NONE;
                flag_q  <= 1'b0;
            end else begin
                cause_q <= cause_d;
                flag_q  <= hit_d;
            end
        end
        assign cause_o   = cause_q;
        assign illegal_o = flag_q;
    end else begin : g_comb
        assign cause_o   = cause_d;
        assign illegal_o = hit_d;
    end

endmodule

// File: rtl/vreg_overlap_sva.sv
module vreg_overlap_sva #(
    parameter int NUM_VREGS = 32,
    parameter int EEW_W     = 2,
    parameter int EMUL_W    = 4,
    parameter int REG_OUT   = 1,
    parameter int RW        = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cls_i,
    input logic              mask_en_i,
    input logic [RW-1:0]     vs1_i,
    input logic [EEW_W-1:0]  vs1_eew_i,
    input logic [EMUL_W-1:0] vs1_emul_i,
    input logic [RW-1:0]     vs2_i,
    input logic [EEW_W-1:0]  vs2_eew_i,
    input logic [EMUL_W-1:0] vs2_emul_i,
    input logic [RW-1:0]     vd_i,
    input logic [EEW_W-1:0]  vd_eew_i,
    input logic [EMUL_W-1:0] vd_emul_i,
    input logic              illegal_o,
    input logic [2:0]        cause_o
);

    localparam int LW = 3 + 3 * (RW + EEW_W + EMUL_W);

    logic [LW-1:0]     now_v;
    logic [LW-1:0]     seen_v;
    logic [1:0]        q_cls;
    logic              q_mask;
    logic [RW-1:0]     q_r1, q_r2, q_rd;
    logic [EEW_W-1:0]  q_e1, q_e2, q_ed;
    logic [EMUL_W-1:0] q_l1, q_l2, q_ld;

    assign now_v = {cls_i, mask_en_i, vs1_i, vs1_eew_i, vs1_emul_i,
                    vs2_i, vs2_eew_i, vs2_emul_i, vd_i, vd_eew_i, vd_emul_i};

    // align the observed inputs with the output latency
    if (REG_OUT != 0) begin : g_lag
        logic [LW-1:0] lag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lag_q <= '0;
            else        lag_q <= now_v;
        end
        assign seen_v = lag_q;
    end else begin : g_nolag
        assign seen_v = now_v;
    end

    assign {q_cls, q_mask, q_r1, q_e1, q_l1, q_r2, q_e2, q_l2, q_rd, q_ed, q_ld} = seen_v;

    assert_flag_agrees_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o == (cause_o != 3'd0));

    assert_cause_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o <= 3'd4);

    assert_same_base_mixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cls == 2'd0 && q_r1 == q_r2 && q_e1 != q_e2) |-> cause_o == 3'd1);

    assert_mask_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !q_mask |-> cause_o != 3'd2);

    assert_wide_scope_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cls == 2'd0 || q_cls == 2'd3) |-> cause_o != 3'd3);

    assert_same_width_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cls == 2'd0 && !q_mask && q_r1 == q_r2 && q_e1 == q_e2 &&
         q_l1 == '0 && q_l2 == '0 && q_ld == '0) |-> cause_o == 3'd0);

    assert_worst_case_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_cls == 2'd2 && q_mask && q_r1 == '0 && q_r2 == '0 && q_rd == '0 &&
         q_e1 == 2'd2 && q_e2 == 2'd2 && q_ed == 2'd3) |-> cause_o == 3'd1);

endmodule

bind vreg_overlap_check vreg_overlap_sva #(
    .NUM_VREGS (NUM_VREGS),
    .EEW_W     (EEW_W),
    .EMUL_W    (EMUL_W),
    .REG_OUT   (REG_OUT),
    .RW        (RW)
) u_sva (.*);

// File: tb/test_vreg_overlap_check.sv
module test_vreg_overlap_check;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cls_i = '0;
    logic       mask_en_i = 1'b0;
    logic [4:0] vs1_i = '0, vs2_i = '0, vd_i = '0;
    logic [1:0] vs1_eew_i = '0, vs2_eew_i = '0, vd_eew_i = '0;
    logic [3:0] vs1_emul_i = '0, vs2_emul_i = '0, vd_emul_i = '0;
    logic       illegal_o;
    logic [2:0] cause_o;

    int checks_n = 0;
    int errors_n = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vreg_overlap_check i_vreg_overlap_check (
        .clk(clk), .rst_n(rst_n), .cls_i(cls_i), .mask_en_i(mask_en_i),
        .vs1_i(vs1_i), .vs1_eew_i(vs1_eew_i), .vs1_emul_i(vs1_emul_i),
        .vs2_i(vs2_i), .vs2_eew_i(vs2_eew_i), .vs2_emul_i(vs2_emul_i),
        .vd_i(vd_i), .vd_eew_i(vd_eew_i), .vd_emul_i(vd_emul_i),
        .illegal_o(illegal_o), .cause_o(cause_o)
    );

    // behavioural reference: expands ranges with integers
    function automatic int ref_cause(input int c, input int m,
        input int r0, input int e0, input int l0,
        input int r1, input int e1, input int l1,
        input int r2, input int e2, input int l2);
        int r[3], e[3], l[3], lo[3], hi[3], cnt[3];
        bit rd[3], use_op[3];
        bit c1, c2, c3, c4;
        r = '{r0, r1, r2}; e = '{e0, e1, e2}; l = '{l0, l1, l2};
        c1 = 0; c2 = 0; c3 = 0; c4 = 0;
        for (int k = 0; k < 3; k++) begin
            cnt[k] = (l[k] > 0) ? (1 << l[k]) : 1;
            lo[k] = r[k];
            hi[k] = r[k] + cnt[k] - 1;
            if (c == 3)      rd[k] = (k != 0);
            else if (c == 2) rd[k] = 1;
            else             rd[k] = (k != 2);
            use_op[k] = (c == 3) ? (k != 0) : 1'b1;
        end
        for (int i = 0; i < 3; i++)
            for (int j = 0; j < 3; j++)
                if (i != j && rd[i] && rd[j] && lo[i] <= hi[j] && lo[j] <= hi[i] && e[i] != e[j])
                    c1 = 1;
        for (int k = 0; k < 3; k++) begin
            if (m != 0 && rd[k] && r[k] == 0) c2 = 1;
            if (use_op[k] && (r[k] % cnt[k]) != 0) c4 = 1;
        end
        if ((c == 1 || c == 2) && (l[2] > 3 || (c == 1 && l[1] > 3))) c3 = 1;
        if (c1) return 1;
        if (c2) return 2;
        if (c3) return 3;
        if (c4) return 4;
        return 0;
    endfunction

    task automatic check_out(input int exp, input string tag);
        checks_n++;
        if (cause_o !== 3'(exp) || illegal_o !== (exp != 0)) begin
            errors_n++;
            $display("FAIL %s: cause=%0d illegal=%0d expected cause=%0d illegal=%0d",
                     tag, cause_o, illegal_o, exp, (exp != 0));
        end
    endtask

    task automatic run_case(input int c, input int m,
        input int r0, input int e0, input int l0,
        input int r1, input int e1, input int l1,
        input int r2, input int e2, input int l2,
        input int exp, input string tag);
        @(negedge clk);
        cls_i = 2'(c); mask_en_i = 1'(m);
        vs1_i = 5'(r0); vs1_eew_i = 2'(e0); vs1_emul_i = 4'(l0);
        vs2_i = 5'(r1); vs2_eew_i = 2'(e1); vs2_emul_i = 4'(l1);
        vd_i  = 5'(r2); vd_eew_i  = 2'(e2); vd_emul_i  = 4'(l2);
        @(negedge clk);
        check_out(exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out(0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out(0, "R1 after reset, zero inputs");

        run_case(0,0,  4,2,0,  4,2,0,  8,2,0,  0, "R9 same register same width");
        run_case(0,0,  8,1,1,  8,1,2, 16,1,0,  0, "R9 overlapping groups same width");
        run_case(0,0,  8,0,0,  8,1,1,  2,0,0,  1, "R2 same base differing width");
        run_case(0,0, 10,2,0,  8,0,2,  4,0,0,  1, "R2 partial overlap inside group");
        run_case(0,0, 12,0,0,  8,1,2,  4,0,0,  0, "R2 adjacent groups no overlap");
        run_case(3,0,  0,0,0,  8,0,0,  8,2,0,  1, "R3 index and data overlap");
        run_case(3,0,  9,3,1,  8,0,1, 16,2,0,  0, "R3 first source ignored");
        run_case(1,0, 10,1,0,  8,2,2, 16,2,2,  1, "R4 narrow inside wide source");
        run_case(1,0,  4,1,1,  8,2,2, 16,2,2,  0, "R4 disjoint wide and narrow");
        run_case(0,1,  0,2,0,  8,2,0,  4,2,0,  2, "R5 source is v0");
        run_case(0,1,  8,1,0,  0,1,3, 16,1,0,  2, "R5 group covers v0");
        run_case(0,0,  0,2,0,  8,2,0,  4,2,0,  0, "R5 masking off");
        run_case(0,1,  4,2,0,  8,2,0,  0,2,0,  0, "R5 written destination at v0");
        run_case(2,0,  0,1,3,  8,1,3, 16,2,4,  3, "R6 accumulator spans 16");
        run_case(0,0,  0,1,3,  8,1,3, 16,1,4,  0, "R6 plain class not checked");
        run_case(1,0,  0,1,3, 16,2,4,  8,2,3,  3, "R6 wide source spans 16");
        run_case(0,0,  3,0,1,  8,0,0, 16,0,0,  4, "R7 misaligned source");
        run_case(0,0,  4,0,0,  8,0,0,  6,0,2,  4, "R7 misaligned destination");
        run_case(0,1,  0,0,0,  0,1,0,  8,0,0,  1, "R8 mixed beats mask");
        run_case(0,1,  0,0,0,  9,0,1, 16,0,0,  2, "R8 mask beats misaligned");
        run_case(2,0,  0,1,3,  8,1,3, 17,2,4,  3, "R8 wide beats misaligned");
        run_case(2,1,  0,2,0,  0,2,0,  0,3,0,  1, "R10 all operands v0");

        for (int n = 0; n < 400; n++) begin
            int c, m, r0, e0, l0, r1, e1, l1, r2, e2, l2;
            c  = $urandom_range(0, 3);  m  = $urandom_range(0, 1);
            r0 = $urandom_range(0, 31); e0 = $urandom_range(0, 3); l0 = $urandom_range(0, 7) - 3;
            r1 = $urandom_range(0, 31); e1 = $urandom_range(0, 3); l1 = $urandom_range(0, 7) - 3;
            r2 = $urandom_range(0, 31); e2 = $urandom_range(0, 3); l2 = $urandom_range(0, 7) - 3;
            if (n % 3 == 0) begin
                r1 = r0 & ~3;
                r2 = r0 & ~7;
            end
            run_case(c, m, r0, e0, l0, r1, e1, l1, r2, e2, l2,
                     ref_cause(c, m, r0, e0, l0, r1, e1, l1, r2, e2, l2),
                     "R8 random vs reference");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks_n, errors_n);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors_n++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks_n, errors_n);
            $finish;
        end
    end

endmodule